// File: doc/BRIEF.md
# Partitioned Vector Register File

A bank of 32 vector registers with one write port and one read port. The registers are wider than the 128-bit architectural view, and the physical width is a parameter. A write carries a register index, a half selector, a size code and data. A lower-half write of any size zero-extends its value. An upper-half write puts 64 bits into bits 127:64 and keeps bits 63:0 of the register.

Above bit 127, a per-write option decides what happens to the rest of the register. The write can wipe the whole physical register. Otherwise only the bits below a vector length supplied on a port are written, and the bits from that length upward are kept. A read returns a zero-extended low slice of the selected size, the upper 64-bit half in the low bits, or the whole physical register.

Illegal half and size pairings raise a one-cycle error flag. An illegal write changes no register.

Top module: `vrf_part_file`

## Requirements
- R1: After reset every register holds zero, `rd_data` is zero, and `rd_err` and `wr_err` are low.
- R2: Size codes are 0=8, 1=16, 2=32, 3=64, 4=128 bits and 5=full physical width. A lower-half write (`wr_part`=0) of code 0 to 3 stores the low 8/16/32/64 bits of `wr_data` and clears every bit above them inside the written region.
- R3: A lower-half write of code 4 stores `wr_data[127:0]` and clears the bits above 127 inside the written region. Code 5 stores all of `wr_data`.
- R4: An upper-half write (`wr_part`=1, code 3) stores `wr_data[63:0]` into bits 127:64 and leaves bits 63:0 unchanged. Bits above 127 follow R8/R9 as a zero-extended 128-bit value.
- R5: A read with `rd_part`=0 and code 0 to 4 returns the low 8/16/32/64/128 bits of the register, with every higher bit of `rd_data` zero.
- R6: A read with `rd_part`=1 and code 3 returns bits 127:64 in `rd_data[63:0]`, with every higher bit zero.
- R7: A read with `rd_part`=0 and code 5 returns the whole physical register.
- R8: With `wipe_full`=1 a legal write replaces the whole physical register by the zero-extended value.
- R9: With `wipe_full`=0 a legal write changes only bits below `vec_len` (a bit count). Bits at or above `vec_len` keep their old value.
- R10: A write with `wr_part`=1 and a code other than 3, or with code 6 or 7, is illegal. `wr_err` is high for the cycle after it, and no register changes. `wr_err` is high at no other time.
- R11: A read with `rd_part`=1 and a code other than 3, or with code 6 or 7, gives `rd_err`=1 and `rd_data`=0 one cycle later.
- R12: All 32 indices, including 31, can be written, and each holds its own value.
- R13: Read results appear one cycle after `rd_en` and hold while `rd_en` is low. A read in the same cycle as a write to the same index returns the contents before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write request |
| wr_idx | input | IDX_W (5) | Write register index |
| wr_part | input | 1 | Write half: 0 lower/full, 1 upper 64 bits |
| wr_size | input | 3 | Write size code |
| wr_data | input | PHYS_W | Write data |
| wipe_full | input | 1 | 1: write clears whole register; 0: keep bits at or above vec_len |
| vec_len | input | LEN_W | Vector length in bits |
| wr_err | output | 1 | Illegal write seen in previous cycle |
| rd_en | input | 1 | Read request |
| rd_idx | input | IDX_W (5) | Read register index |
| rd_part | input | 1 | Read half: 0 low slice, 1 upper 64 bits |
| rd_size | input | 3 | Read size code |
| rd_data | output | PHYS_W | Read result |
| rd_err | output | 1 | Last read was illegal |

## Verification
The hardest case to reach is the one where bits above the vector length survive a narrow write. Reset leaves those bits at zero, and no architectural-width write can set them. The stimulus first fills a register with ones through a full physical-width write with wiping on. It then lowers `vec_len` to a value between 128 and the physical width and issues a narrow write with wiping off. A full-width read then shows three bands: the written value, the zero-extension up to the length, and the untouched ones above it. A read issued in the same cycle as a write to the same index checks the old-contents rule.

// File: rtl/vrf_part_pkg.sv
package vrf_part_pkg;

    // Size codes shared by both ports
    typedef enum logic [2:0] {
        SZ_B8   = 3'd0,
        SZ_B16  = 3'd1,
        SZ_B32  = 3'd2,
        SZ_B64  = 3'd3,
        SZ_B128 = 3'd4,
        SZ_PHYS = 3'd5
    } vsize_e;

    // Upper half accepts only the 64-bit size; lower half accepts codes 0..5
    function automatic logic access_legal(input logic part, input logic [2:0] sz);
        if (part) begin
            return sz == SZ_B64;
        end
        return sz <= SZ_PHYS;
    endfunction

    // Bit width selected by a size code; the full code maps to the physical width
    function automatic int size_bits(input logic [2:0] sz, input int phys_w);
        case (sz)
            SZ_B8:   return 8;
            SZ_B16:  return 16;
            SZ_B32:  return 32;
            SZ_B64:  return 64;
            SZ_B128: return 128;
            default: return phys_w;
        endcase
    endfunction

endpackage

// File: rtl/vrf_size_mask.sv
module vrf_size_mask #(
    parameter int PHYS_W = 256
) (
    input  logic [2:0]        sz,
    output logic [PHYS_W-1:0] mask
);
    import vrf_part_pkg::*;

    int width;
    assign width = size_bits(sz, PHYS_W);

    for (genvar i = 0; i < PHYS_W; i++) begin : g_bit
        assign mask[i] = (i < width);
    end
endmodule

// File: rtl/vrf_len_mask.sv
module vrf_len_mask #(
    parameter int PHYS_W = 256,
    localparam int LEN_W = $clog2(PHYS_W + 1)
) (
    input  logic [LEN_W-1:0]  len,
    output logic [PHYS_W-1:0] mask
);
    for (genvar i = 0; i < PHYS_W; i++) begin : g_bit
        assign mask[i] = (LEN_W'(i) < len);
    end
endmodule

// File: rtl/vrf_wr_merge.sv
module vrf_wr_merge #(
    parameter int PHYS_W = 256,
    localparam int LEN_W = $clog2(PHYS_W + 1)
) (
    input  logic [PHYS_W-1:0] old_val,
    input  logic [PHYS_W-1:0] data,
    input  logic              part,
    input  logic [2:0]        sz,
    input  logic              wipe,
    input  logic [LEN_W-1:0]  len,
    output logic [PHYS_W-1:0] new_val
);
    logic [PHYS_W-1:0] sz_mask;
    logic [PHYS_W-1:0] len_mask;
    logic [PHYS_W-1:0] ext;
    logic [PHYS_W-1:0] region;

    vrf_size_mask #(.PHYS_W(PHYS_W)) u_sz  (.sz(sz),   .mask(sz_mask));
    vrf_len_mask  #(.PHYS_W(PHYS_W)) u_len (.len(len), .mask(len_mask));

    always_comb begin
        ext = data & sz_mask;
        if (part) begin
            // upper-half insert: new high 64 over preserved low 64, zero-extended
            ext          = '0;
            ext[127:64]  = data[63:0];
            ext[63:0]    = old_val[63:0];
        end
        region  = wipe ? '1 : len_mask;
        new_val = (ext & region) | (old_val & ~region);
    end
endmodule

// File: rtl/vrf_rd_slice.sv
module vrf_rd_slice #(
    parameter int PHYS_W = 256
) (
    input  logic [PHYS_W-1:0] reg_val,
    input  logic              part,
    input  logic [2:0]        sz,
    output logic [PHYS_W-1:0] dout
);
    logic [PHYS_W-1:0] sz_mask;

    vrf_size_mask #(.PHYS_W(PHYS_W)) u_sz (.sz(sz), .mask(sz_mask));

    always_comb begin
        dout = reg_val & sz_mask;
        if (part) begin
            dout       = '0;
            dout[63:0] = reg_val[127:64];
        end
    end
endmodule

// File: rtl/vrf_part_file.sv
module vrf_part_file #(
    parameter int PHYS_W = 256,
    parameter int NREG   = 32,
    localparam int IDX_W = $clog2(NREG),
    localparam int LEN_W = $clog2(PHYS_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              wr_part,
    input  logic [2:0]        wr_size,
    input  logic [PHYS_W-1:0] wr_data,
    input  logic              wipe_full,
    input  logic [LEN_W-1:0]  vec_len,
    output logic              wr_err,
    input  logic              rd_en,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic              rd_part,
    input  logic [2:0]        rd_size,
    output logic [PHYS_W-1:0] rd_data,
    output logic              rd_err
);
    import vrf_part_pkg::*;

    typedef struct packed {
        logic [NREG-1:0][PHYS_W-1:0] regs;
        logic [PHYS_W-1:0]           rd_data;
        logic                        rd_err;
        logic                        wr_err;
    } state_t;

    state_t s_d, s_q;

    logic [PHYS_W-1:0] merged;
    logic [PHYS_W-1:0] sliced;

    vrf_wr_merge #(.PHYS_W(PHYS_W)) u_merge (
        .old_val (s_q.regs[wr_idx]),
        .data    (wr_data),
        .part    (wr_part),
        .sz      (wr_size),
        .wipe    (wipe_full),
        .len     (vec_len),
        .new_val (merged)
    );

    vrf_rd_slice #(.PHYS_W(PHYS_W)) u_slice (
        .reg_val (s_q.regs[rd_idx]),
        .part    (rd_part),
        .sz      (rd_size),
        .dout    (sliced)
    );

    always_comb begin
        s_d        = s_q;
        s_d.wr_err = 1'b0;
        if (wr_en) begin
            if (access_legal(wr_part, wr_size)) begin
                s_d.regs[wr_idx] = merged;
            end else begin
                s_d.wr_err = 1'b1;
            end
        end
        if (rd_en) begin
            if (access_legal(rd_part, rd_size)) begin
                s_d.rd_data = sliced;
                s_d.rd_err  = 1'b0;
            end else begin
                s_d.rd_data = '0;
                s_d.rd_err  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign wr_err  = s_q.wr_err;
    assign rd_err  = s_q.rd_err;
    assign rd_data = s_q.rd_data;
endmodule

// File: rtl/vrf_part_file_chk.sv
module vrf_part_file_chk #(
    parameter int PHYS_W = 256
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              wr_part,
    input logic [2:0]        wr_size,
    input logic              wr_err,
    input logic              rd_en,
    input logic              rd_part,
    input logic [2:0]        rd_size,
    input logic [PHYS_W-1:0] rd_data,
    input logic              rd_err
);
    import vrf_part_pkg::*;

    // R10
    wr_illegal_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !access_legal(wr_part, wr_size)) |=> wr_err);

    // R10
    wr_err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err |-> $past(wr_en && !access_legal(wr_part, wr_size)));

    // R11
    rd_illegal_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !access_legal(rd_part, rd_size)) |=> (rd_err && rd_data == '0));

    // R6
    rd_upper_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_part && rd_size == 3'd3) |=> (!rd_err && rd_data[PHYS_W-1:64] == '0));

    // R5
    rd_low_slice_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !rd_part && rd_size <= 3'd3) |=> ((rd_data >> (8 << $past(rd_size))) == '0));

    // R13
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> ($stable(rd_data) && $stable(rd_err)));
endmodule

bind vrf_part_file vrf_part_file_chk #(.PHYS_W(PHYS_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_part (wr_part),
    .wr_size (wr_size),
    .wr_err  (wr_err),
    .rd_en   (rd_en),
    .rd_part (rd_part),
    .rd_size (rd_size),
    .rd_data (rd_data),
    .rd_err  (rd_err)
);

// File: tb/vrf_part_file_test.sv
module vrf_part_file_test;
    localparam int PW         = 256;
    localparam int LW         = $clog2(PW + 1);
    localparam int CLK_PERIOD = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [4:0]    wr_idx = '0;
    logic          wr_part = 1'b0;
    logic [2:0]    wr_size = '0;
    logic [PW-1:0] wr_data = '0;
    logic          wipe_full = 1'b1;
    logic [LW-1:0] vec_len = LW'(PW);
    logic          wr_err;
    logic          rd_en = 1'b0;
    logic [4:0]    rd_idx = '0;
    logic          rd_part = 1'b0;
    logic [2:0]    rd_size = '0;
    logic [PW-1:0] rd_data;
    logic          rd_err;

    int n_checks = 0;
    int n_fails  = 0;
    logic [PW-1:0] got;
    logic          got_err;

    always #(CLK_PERIOD/2) clk = ~clk;

    vrf_part_file #(.PHYS_W(PW), .NREG(32)) uut (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_part(wr_part), .wr_size(wr_size),
        .wr_data(wr_data), .wipe_full(wipe_full), .vec_len(vec_len), .wr_err(wr_err),
        .rd_en(rd_en), .rd_idx(rd_idx), .rd_part(rd_part), .rd_size(rd_size),
        .rd_data(rd_data), .rd_err(rd_err)
    );

    task automatic check(input string tag, input logic [PW-1:0] act, input logic [PW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input int idx, input logic part, input logic [2:0] sz,
                      input logic [PW-1:0] data, input logic wipe, input int len);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 5'(idx); wr_part = part; wr_size = sz;
        wr_data = data; wipe_full = wipe; vec_len = LW'(len);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int idx, input logic part, input logic [2:0] sz);
        @(negedge clk);
        rd_en = 1'b1; rd_idx = 5'(idx); rd_part = part; rd_size = sz;
        @(negedge clk);
        rd_en = 1'b0;
        got = rd_data; got_err = rd_err;
    endtask

    task automatic t_reset;
        check("R1 wr_err", PW'(wr_err), '0);
        check("R1 rd_err", PW'(rd_err), '0);
        check("R1 rd_data", rd_data, '0);
        rd(9, 1'b0, 3'd5);
        check("R1 reg9 zero", got, '0);
    endtask

    task automatic t_all_index;
        for (int i = 0; i < 32; i++)
            wr(i, 1'b0, 3'd3, {192'hFFFF, 56'hA5_0000_0000_0000, 8'(i)}, 1'b1, PW);
        for (int i = 0; i < 32; i++) begin
            rd(i, 1'b0, 3'd5);
            check("R12 index readback", got, {192'h0, 56'hA5_0000_0000_0000, 8'(i)});
        end
    endtask

    task automatic t_wipe;
        wr(3, 1'b0, 3'd5, '1, 1'b1, PW);
        rd(3, 1'b0, 3'd5);
        check("R3 R7 phys write", got, '1);
        wr(3, 1'b0, 3'd0, '1, 1'b1, 160);
        rd(3, 1'b0, 3'd5);
        check("R8 R2 wipe 8-bit", got, PW'(8'hFF));
    endtask

    task automatic t_keep_above_len;
        wr(4, 1'b0, 3'd5, '1, 1'b1, PW);
        wr(4, 1'b0, 3'd1, {128'hFFFF, 96'h0, 32'h1234_ABCD}, 1'b0, 160);
        rd(4, 1'b0, 3'd5);
        check("R9 R2 keep above len", got, ({PW{1'b1}} << 160) | PW'(16'hABCD));
    endtask

    task automatic t_full128;
        wr(5, 1'b0, 3'd5, '1, 1'b1, PW);
        wr(5, 1'b0, 3'd4, {128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF,
                           128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210}, 1'b0, PW);
        rd(5, 1'b0, 3'd5);
        check("R3 128-bit zero-extend", got, {128'h0, 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210});
    endtask

    task automatic t_upper_half;
        wr(6, 1'b0, 3'd4, {128'hFF, 128'h1111_2222_3333_4444_5555_6666_7777_8888}, 1'b1, PW);
        wr(6, 1'b1, 3'd3, {192'hFFFF, 64'hCAFE_BABE_0BAD_F00D}, 1'b1, PW);
        rd(6, 1'b0, 3'd5);
        check("R4 upper insert", got, {128'h0, 64'hCAFE_BABE_0BAD_F00D, 64'h5555_6666_7777_8888});
        rd(6, 1'b1, 3'd3);
        check("R6 upper read", got, PW'(64'hCAFE_BABE_0BAD_F00D));
        rd(6, 1'b0, 3'd2);
        check("R5 32-bit read", got, PW'(32'h7777_8888));
        rd(6, 1'b0, 3'd0);
        check("R5 8-bit read", got, PW'(8'h88));
        rd(6, 1'b0, 3'd4);
        check("R5 128-bit read", got, {128'h0, 64'hCAFE_BABE_0BAD_F00D, 64'h5555_6666_7777_8888});
    endtask

    task automatic t_bad_write;
        wr(6, 1'b1, 3'd2, '1, 1'b1, PW);
        check("R10 err part1 size2", PW'(wr_err), PW'(1));
        wr(6, 1'b0, 3'd6, '1, 1'b1, PW);
        check("R10 err code6", PW'(wr_err), PW'(1));
        @(negedge clk);
        check("R10 err clears", PW'(wr_err), '0);
        rd(6, 1'b0, 3'd5);
        check("R10 reg unchanged", got, {128'h0, 64'hCAFE_BABE_0BAD_F00D, 64'h5555_6666_7777_8888});
    endtask

    task automatic t_bad_read;
        rd(6, 1'b1, 3'd4);
        check("R11 rd_err", PW'(got_err), PW'(1));
        check("R11 rd_data zero", got, '0);
        rd(6, 1'b0, 3'd7);
        check("R11 code7 err", PW'(got_err), PW'(1));
        rd(6, 1'b1, 3'd3);
        check("R11 err clears on legal", PW'(got_err), '0);
    endtask

    task automatic t_same_cycle;
        wr(7, 1'b0, 3'd3, PW'(64'h1111), 1'b1, PW);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 5'd7; wr_part = 1'b0; wr_size = 3'd3;
        wr_data = PW'(64'h2222); wipe_full = 1'b1; vec_len = LW'(PW);
        rd_en = 1'b1; rd_idx = 5'd7; rd_part = 1'b0; rd_size = 3'd3;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        check("R13 old value on collision", rd_data, PW'(64'h1111));
        repeat (2) @(negedge clk);
        check("R13 held while idle", rd_data, PW'(64'h1111));
        rd(7, 1'b0, 3'd3);
        check("R13 new value next read", got, PW'(64'h2222));
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_all_index();
        t_wipe();
        t_keep_above_len();
        t_full128();
        t_upper_half();
        t_bad_write();
        t_bad_read();
        t_same_cycle();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule